// File: doc/BRIEF.md
# Packed-Lane Saturating Integer Unit

This unit treats a 32-bit word as a small vector of integer lanes and applies one operation to every lane at once. It can split the word into four 8-bit lanes or two 16-bit lanes, and each lane can be read as signed or unsigned. The operations are:

- add and subtract, either wrapping or clamping;
- halving add and subtract, with or without rounding;
- absolute value;
- logical and arithmetic right shifts, with optional rounding on the arithmetic shift;
- left shift, either wrapping or clamping.

A caller presents two operand words, an opcode, a lane format, a signedness select and a shift amount, then pulses start. One cycle later the packed result appears with a one-cycle valid strobe. A lane result that falls outside the lane's range raises an overflow event. The event sets a sticky bit in an 8-bit overflow field: bit 4 for add, subtract and absolute value, and bit 6 for left shifts. The bits stay set until a masked clear port removes them.

Top module: `simd_sat_alu`

## Requirements
- R1: fmt_i=0 selects four 8-bit lanes and fmt_i=1 selects two 16-bit lanes, with lane 0 in the least significant bits. Opcodes are 0 add, 1 add-clamp, 2 sub, 3 sub-clamp, 4 half-add, 5 half-add-round, 6 half-sub, 7 half-sub-round, 8 abs, 9 logical right shift, 10 arithmetic right shift, 11 rounding arithmetic right shift, 12 left shift and 13 left shift-clamp. Opcodes 14 and 15 give a zero result and raise no flag.
- R2: The result and valid_o are registered in the cycle after a start_i pulse. valid_o is high for exactly that cycle, and result_o holds its value until the next start.
- R3: Wrapping add and sub keep the low lane bits. When the exact lane result lies outside the lane range, they still set overflow bit 4. The lane range is -2^(W-1)..2^(W-1)-1 when sign_i=1 and 0..2^W-1 when sign_i=0.
- R4: Clamping add and sub replace a lane result above the maximum with the maximum and a result below the minimum with the minimum, and set overflow bit 4.
- R5: A halving add or sub gives (a±b)>>1 computed at full precision with an arithmetic shift. The rounding variants add 1 before the shift. These operations never raise overflow.
- R6: Abs always reads lanes as signed. The most negative lane value gives the lane maximum and sets bit 4. Other negative lanes are negated.
- R7: The shift amount is masked to 3 bits for 8-bit lanes and 4 bits for 16-bit lanes. The logical right shift reads lanes as unsigned.
- R8: The arithmetic right shift reads lanes as signed. The rounding variant adds 2^(sa-1) before shifting, and adds nothing when sa is 0.
- R9: The left shift checks the shifted value against the lane range selected by sign_i and sets bit 6 when it is out of range. The clamping variant clamps the value and the plain variant wraps it.
- R10: Overflow bits are sticky. A clr_i cycle clears the bits set in clr_mask_i. A new event in the same cycle takes priority over the clear. Bits other than 4 and 6 read as 0.
- R11: After reset, result_o, valid_o and ovf_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch an operation |
| op_i | input | 4 | Opcode |
| fmt_i | input | 1 | Lane format: 0 = 4x8, 1 = 2x16 |
| sign_i | input | 1 | Signed lanes when 1 |
| sa_i | input | 4 | Shift amount (masked per format) |
| a_i | input | 32 | First operand word |
| b_i | input | 32 | Second operand word |
| clr_i | input | 1 | Clear strobe for the overflow field |
| clr_mask_i | input | 8 | Bits of the overflow field to clear |
| result_o | output | 32 | Packed lane result |
| valid_o | output | 1 | Result strobe |
| ovf_o | output | 8 | Sticky overflow field |

## Verification
The hardest situation to reach is a clear and a new overflow event arriving in the same cycle, because the two must land on the same edge. The stimulus first sets one bit and clears it. It then raises start_i with an overflowing add and clr_i with a full mask together, and checks that the bit survives. A second awkward point is the lane extremes, such as the most negative value in abs, a halving subtract of the two extremes, and a left shift to the top bit of an unsigned lane. The vector table reaches each of these with operands chosen so that every lane of the word lands in a different regime.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;
  localparam int DATA_W   = 32;
  localparam int NARROW_W = 8;
  localparam int WIDE_W   = 16;
  localparam int SA_W     = $clog2(WIDE_W);
  localparam int FLAG_W   = 8;
  localparam int OVF_ARITH_BIT = 4;
  localparam int OVF_SHL_BIT   = 6;

  typedef enum logic [3:0] {
    OP_ADD      = 4'd0,
    OP_ADD_SAT  = 4'd1,
    OP_SUB      = 4'd2,
    OP_SUB_SAT  = 4'd3,
    OP_HADD     = 4'd4,
    OP_HADD_RND = 4'd5,
    OP_HSUB     = 4'd6,
    OP_HSUB_RND = 4'd7,
    OP_ABS      = 4'd8,
    OP_SHRL     = 4'd9,
    OP_SHRA     = 4'd10,
    OP_SHRA_RND = 4'd11,
    OP_SHLL     = 4'd12,
    OP_SHLL_SAT = 4'd13,
    OP_RSV0     = 4'd14,
    OP_RSV1     = 4'd15
  } op_e;
endpackage

// File: rtl/simd_lane.sv
module simd_lane
  import simd_alu_pkg::*;
#(
  parameter int W   = 8,
  parameter int SAW = $clog2(W)
) (
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  input  op_e            op_i,
  input  logic           sgn_i,
  input  logic [SAW-1:0] sa_i,
  output logic [W-1:0]   y_o,
  output logic           ovf_arith_o,
  output logic           ovf_shl_o
);
  localparam int V = 2*W + 2;
  localparam logic signed [V-1:0] SMAX = {{(V-W+1){1'b0}}, {(W-1){1'b1}}};
  localparam logic signed [V-1:0] SMIN = {{(V-W+1){1'b1}}, {(W-1){1'b0}}};
  localparam logic signed [V-1:0] UMAX = {{(V-W){1'b0}}, {W{1'b1}}};
  localparam logic signed [V-1:0] UMIN = '0;
  localparam logic signed [V-1:0] ONE  = {{(V-1){1'b0}}, 1'b1};
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

  logic signed [V-1:0] av, bv, as_v, hi, lo, tmp, half;
  logic out_hi, out_lo;

  // operand extension per signedness; abs and shra always signed
  assign av   = sgn_i ? {{(V-W){a_i[W-1]}}, a_i} : {{(V-W){1'b0}}, a_i};
  assign bv   = sgn_i ? {{(V-W){b_i[W-1]}}, b_i} : {{(V-W){1'b0}}, b_i};
  assign as_v = {{(V-W){a_i[W-1]}}, a_i};
  assign hi   = sgn_i ? SMAX : UMAX;
  assign lo   = sgn_i ? SMIN : UMIN;
  assign half = (ONE << sa_i) >>> 1;

  always_comb begin
    tmp         = '0;
    y_o         = '0;
    ovf_arith_o = 1'b0;
    ovf_shl_o   = 1'b0;
    out_hi      = 1'b0;
    out_lo      = 1'b0;
    unique case (op_i)
      OP_ADD, OP_ADD_SAT, OP_SUB, OP_SUB_SAT: begin
        tmp = (op_i == OP_ADD || op_i == OP_ADD_SAT) ? av + bv : av - bv;
        out_hi = tmp > hi;
        out_lo = tmp < lo;
        ovf_arith_o = out_hi | out_lo;
        if (op_i == OP_ADD_SAT || op_i == OP_SUB_SAT) begin
          if (out_hi) tmp = hi;
          else if (out_lo) tmp = lo;
        end
        y_o = tmp[W-1:0];
      end
      OP_HADD, OP_HADD_RND: begin
        tmp = av + bv + ((op_i == OP_HADD_RND) ? ONE : '0);
        y_o = tmp[W:1];
      end
      OP_HSUB, OP_HSUB_RND: begin
        tmp = av - bv + ((op_i == OP_HSUB_RND) ? ONE : '0);
        y_o = tmp[W:1];
      end
      OP_ABS: begin
        if (a_i == MOST_NEG) begin
          y_o = SMAX[W-1:0];
          ovf_arith_o = 1'b1;
        end else if (a_i[W-1]) begin
          y_o = -a_i;
        end else begin
          y_o = a_i;
        end
      end
      OP_SHRL: y_o = a_i >> sa_i;
      OP_SHRA, OP_SHRA_RND: begin
        tmp = as_v + ((op_i == OP_SHRA_RND) ? half : '0);
        tmp = tmp >>> sa_i;
        y_o = tmp[W-1:0];
      end
      OP_SHLL, OP_SHLL_SAT: begin
        tmp = av <<< sa_i;
        out_hi = tmp > hi;
        out_lo = tmp < lo;
        ovf_shl_o = out_hi | out_lo;
        if (op_i == OP_SHLL_SAT) begin
          if (out_hi) tmp = hi;
          else if (out_lo) tmp = lo;
        end
        y_o = tmp[W-1:0];
      end
      default: y_o = '0;
    endcase
  end
endmodule

// File: rtl/simd_sticky.sv
module simd_sticky #(
  parameter int FW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [FW-1:0] set_i,
  input  logic          clr_i,
  input  logic [FW-1:0] clr_mask_i,
  output logic [FW-1:0] flags_o
);
  logic [FW-1:0] flags_q;

  // set wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= (flags_q & ~(clr_i ? clr_mask_i : '0)) | set_i;
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/simd_sat_alu.sv
module simd_sat_alu
  import simd_alu_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [3:0]        op_i,
  input  logic              fmt_i,
  input  logic              sign_i,
  input  logic [SA_W-1:0]   sa_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              clr_i,
  input  logic [FLAG_W-1:0] clr_mask_i,
  output logic [DATA_W-1:0] result_o,
  output logic              valid_o,
  output logic [FLAG_W-1:0] ovf_o
);
  localparam int N_NARROW = DATA_W / NARROW_W;
  localparam int N_WIDE   = DATA_W / WIDE_W;
  localparam int SA_N     = $clog2(NARROW_W);

  op_e op;
  assign op = op_e'(op_i);

  logic [DATA_W-1:0]   res_n, res_w;
  logic [N_NARROW-1:0] oa_n, os_n;
  logic [N_WIDE-1:0]   oa_w, os_w;

  for (genvar g = 0; g < N_NARROW; g++) begin : g_narrow
    simd_lane #(.W(NARROW_W), .SAW(SA_N)) u_lane (
      .a_i        (a_i[g*NARROW_W +: NARROW_W]),
      .b_i        (b_i[g*NARROW_W +: NARROW_W]),
      .op_i       (op),
      .sgn_i      (sign_i),
      .sa_i       (sa_i[SA_N-1:0]),
      .y_o        (res_n[g*NARROW_W +: NARROW_W]),
      .ovf_arith_o(oa_n[g]),
      .ovf_shl_o  (os_n[g])
    );
  end

  for (genvar h = 0; h < N_WIDE; h++) begin : g_wide
    simd_lane #(.W(WIDE_W), .SAW(SA_W)) u_lane (
      .a_i        (a_i[h*WIDE_W +: WIDE_W]),
      .b_i        (b_i[h*WIDE_W +: WIDE_W]),
      .op_i       (op),
      .sgn_i      (sign_i),
      .sa_i       (sa_i),
      .y_o        (res_w[h*WIDE_W +: WIDE_W]),
      .ovf_arith_o(oa_w[h]),
      .ovf_shl_o  (os_w[h])
    );
  end

  logic [FLAG_W-1:0] set_vec;
  always_comb begin
    set_vec = '0;
    set_vec[OVF_ARITH_BIT] = start_i & (fmt_i ? |oa_w : |oa_n);
    set_vec[OVF_SHL_BIT]   = start_i & (fmt_i ? |os_w : |os_n);
  end

  simd_sticky #(.FW(FLAG_W)) u_sticky (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (set_vec),
    .clr_i     (clr_i),
    .clr_mask_i(clr_mask_i),
    .flags_o   (ovf_o)
  );

  logic [DATA_W-1:0] result_q;
  logic              valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_q <= '0;
      valid_q  <= 1'b0;
    end else begin
      valid_q <= start_i;
      if (start_i) result_q <= fmt_i ? res_w : res_n;
    end
  end

  assign result_o = result_q;
  assign valid_o  = valid_q;
endmodule

// File: rtl/simd_sat_alu_chk.sv
module simd_sat_alu_chk
  import simd_alu_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              clr_i,
  input logic [FLAG_W-1:0] clr_mask_i,
  input logic [DATA_W-1:0] result_o,
  input logic              valid_o,
  input logic [FLAG_W-1:0] ovf_o
);
  localparam logic [FLAG_W-1:0] LIVE =
    (FLAG_W'(1) << OVF_ARITH_BIT) | (FLAG_W'(1) << OVF_SHL_BIT);

  p_valid_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> valid_o);
  p_valid_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !valid_o);
  p_result_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> $stable(result_o));
  p_sticky_arith_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o[OVF_ARITH_BIT] && !(clr_i && clr_mask_i[OVF_ARITH_BIT])) |=> ovf_o[OVF_ARITH_BIT]);
  p_sticky_shl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o[OVF_SHL_BIT] && !(clr_i && clr_mask_i[OVF_SHL_BIT])) |=> ovf_o[OVF_SHL_BIT]);
  p_quiet_flags_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && !clr_i) |=> $stable(ovf_o));
  p_clear_arith_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && clr_mask_i[OVF_ARITH_BIT] && !start_i) |=> !ovf_o[OVF_ARITH_BIT]);
  p_spare_bits_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o & ~LIVE) == '0);
endmodule

bind simd_sat_alu simd_sat_alu_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .clr_i     (clr_i),
  .clr_mask_i(clr_mask_i),
  .result_o  (result_o),
  .valid_o   (valid_o),
  .ovf_o     (ovf_o)
);

// File: tb/simd_sat_alu_bench.sv
module simd_sat_alu_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [3:0]  op_i = '0;
  logic        fmt_i = 1'b0;
  logic        sign_i = 1'b0;
  logic [3:0]  sa_i = '0;
  logic [31:0] a_i = '0;
  logic [31:0] b_i = '0;
  logic        clr_i = 1'b0;
  logic [7:0]  clr_mask_i = '0;
  logic [31:0] result_o;
  logic        valid_o;
  logic [7:0]  ovf_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk_i = ~clk_i;

  simd_sat_alu u_simd_sat_alu (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .op_i(op_i),
    .fmt_i(fmt_i), .sign_i(sign_i), .sa_i(sa_i), .a_i(a_i), .b_i(b_i),
    .clr_i(clr_i), .clr_mask_i(clr_mask_i),
    .result_o(result_o), .valid_o(valid_o), .ovf_o(ovf_o)
  );

  typedef struct packed {
    logic [7:0]  req;
    logic [3:0]  op;
    logic        fmt;
    logic        sgn;
    logic [3:0]  sa;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] exp;
    logic [7:0]  flg;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{8'd3,  4'd0,  1'b0, 1'b0, 4'd0,  32'h01020304, 32'h10203040, 32'h11223344, 8'h00}, // R3
    '{8'd3,  4'd0,  1'b0, 1'b0, 4'd0,  32'hFF000080, 32'h01000080, 32'h00000000, 8'h10}, // R3 wrap
    '{8'd4,  4'd1,  1'b0, 1'b0, 4'd0,  32'hFF000080, 32'h01000080, 32'hFF0000FF, 8'h10}, // R4
    '{8'd4,  4'd1,  1'b0, 1'b1, 4'd0,  32'h7F800102, 32'h01FF0304, 32'h7F800406, 8'h10}, // R4 signed
    '{8'd4,  4'd3,  1'b1, 1'b0, 4'd0,  32'h00051000, 32'h00060001, 32'h00000FFF, 8'h10}, // R4 16b
    '{8'd3,  4'd2,  1'b1, 1'b1, 4'd0,  32'h80000010, 32'h00010020, 32'h7FFFFFF0, 8'h10}, // R3 16b
    '{8'd5,  4'd4,  1'b0, 1'b0, 4'd0,  32'hFF030102, 32'hFF000101, 32'hFF010101, 8'h00}, // R5
    '{8'd5,  4'd5,  1'b0, 1'b0, 4'd0,  32'hFF030102, 32'hFF000101, 32'hFF020102, 8'h00}, // R5 round
    '{8'd5,  4'd6,  1'b1, 1'b1, 4'd0,  32'h80000003, 32'h7FFF0000, 32'h80000001, 8'h00}, // R5
    '{8'd5,  4'd7,  1'b1, 1'b1, 4'd0,  32'h80000003, 32'h7FFF0000, 32'h80010002, 8'h00}, // R5 round
    '{8'd6,  4'd8,  1'b0, 1'b0, 4'd0,  32'h80FF7F05, 32'h00000000, 32'h7F017F05, 8'h10}, // R6
    '{8'd6,  4'd8,  1'b1, 1'b0, 4'd0,  32'hFFFE0001, 32'h00000000, 32'h00020001, 8'h00}, // R6
    '{8'd7,  4'd9,  1'b0, 1'b1, 4'hB,  32'h80F01008, 32'h00000000, 32'h101E0201, 8'h00}, // R7 mask
    '{8'd8,  4'd10, 1'b1, 1'b0, 4'd4,  32'h80007FF0, 32'h00000000, 32'hF80007FF, 8'h00}, // R8
    '{8'd8,  4'd11, 1'b0, 1'b0, 4'd2,  32'h7FFE0605, 32'h00000000, 32'h20000201, 8'h00}, // R8 round
    '{8'd8,  4'd11, 1'b0, 1'b0, 4'd0,  32'h12345678, 32'h00000000, 32'h12345678, 8'h00}, // R8 sa=0
    '{8'd9,  4'd12, 1'b0, 1'b0, 4'd1,  32'h80400102, 32'h00000000, 32'h00800204, 8'h40}, // R9 wrap
    '{8'd9,  4'd13, 1'b0, 1'b1, 4'd1,  32'h40C03FBF, 32'h00000000, 32'h7F807E80, 8'h40}, // R9 clamp
    '{8'd9,  4'd13, 1'b1, 1'b0, 4'd15, 32'h00010000, 32'h00000000, 32'h80000000, 8'h00}, // R9 edge
    '{8'd1,  4'd14, 1'b0, 1'b1, 4'd0,  32'hFFFFFFFF, 32'h80808080, 32'h00000000, 8'h00}  // R1 reserved
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clear_all();
    @(negedge clk_i);
    clr_i = 1'b1; clr_mask_i = 8'hFF;
    @(negedge clk_i);
    clr_i = 1'b0; clr_mask_i = 8'h00;
  endtask

  task automatic launch(input logic [3:0] op, input logic fmt, input logic sgn,
                        input logic [3:0] sa, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk_i);
    op_i = op; fmt_i = fmt; sign_i = sgn; sa_i = sa; a_i = a; b_i = b;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R11 reset state
    chk("R11 result", result_o, 32'h0);
    chk("R11 valid", {31'h0, valid_o}, 32'h1 - 32'h1);
    chk("R11 flags", {24'h0, ovf_o}, 32'h0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      clear_all();
      launch(VECS[i].op, VECS[i].fmt, VECS[i].sgn, VECS[i].sa, VECS[i].a, VECS[i].b);
      chk($sformatf("R%0d vec%0d result", VECS[i].req, i), result_o, VECS[i].exp);
      chk($sformatf("R%0d vec%0d flags", VECS[i].req, i), {24'h0, ovf_o}, {24'h0, VECS[i].flg});
      chk("R2 valid strobe", {31'h0, valid_o}, 32'h1);
    end

    // R2: valid drops, result held
    @(negedge clk_i);
    chk("R2 valid low", {31'h0, valid_o}, 32'h0);
    chk("R2 hold", result_o, 32'h00000000);

    // R10 sticky behaviour
    clear_all();
    launch(4'd0, 1'b0, 1'b0, 4'd0, 32'h000000FF, 32'h00000001);
    launch(4'd0, 1'b0, 1'b0, 4'd0, 32'h00000001, 32'h00000001);
    chk("R10 sticky after clean op", {24'h0, ovf_o}, 32'h10);
    launch(4'd12, 1'b1, 1'b0, 4'd1, 32'h80000000, 32'h0);
    chk("R10 both bits", {24'h0, ovf_o}, 32'h50);
    @(negedge clk_i);
    clr_i = 1'b1; clr_mask_i = 8'h40;
    @(negedge clk_i);
    clr_i = 1'b0; clr_mask_i = 8'h00;
    chk("R10 masked clear", {24'h0, ovf_o}, 32'h10);
    @(negedge clk_i);
    clr_i = 1'b1; clr_mask_i = 8'h10;
    @(negedge clk_i);
    clr_i = 1'b0; clr_mask_i = 8'h00;
    chk("R10 clear bit4", {24'h0, ovf_o}, 32'h00);
    // same-cycle clear and event: event wins
    @(negedge clk_i);
    op_i = 4'd0; fmt_i = 1'b0; sign_i = 1'b1; a_i = 32'h0000007F; b_i = 32'h00000001;
    start_i = 1'b1; clr_i = 1'b1; clr_mask_i = 8'hFF;
    @(negedge clk_i);
    start_i = 1'b0; clr_i = 1'b0; clr_mask_i = 8'h00;
    chk("R10 set beats clear", {24'h0, ovf_o}, 32'h10);
    chk("R3 signed wrap", result_o, 32'h00000080);

    // R1: same operands, two formats
    clear_all();
    launch(4'd1, 1'b1, 1'b0, 4'd0, 32'h00FF00FF, 32'h00010001);
    chk("R1 16b carry crosses byte", result_o, 32'h01000100);
    chk("R1 16b no ovf", {24'h0, ovf_o}, 32'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule